// File: doc/BRIEF.md
# Zero-Voltage Transition Pulse Reporter

This block sits beside a half-bridge gate driver and watches two digitized comparator flags taken from the switch node. One flag (`below_flag`) says the node has swung below ground by a threshold, meaning the low-side FET is conducting in reverse. The other (`above_flag`) says the node has risen above the supply by a threshold, meaning the high-side FET is conducting in reverse. A flag counts only if it stays asserted for longer than a minimum time within one switching transition. A counted event is reported to the controller as a fixed-width active-low pulse on the output for that side. The controller uses these pulses to trim its dead-times.

Switching transitions are delimited by edges of the low-side control input `li_in`. Low-side events are reported after a fixed delay from the cycle in which they qualify. High-side events are held back by one full PWM period. Such an event is reported a fixed delay after the next `li_in` edge in the same direction as the edge that opened the transition in which it qualified. Reporting only runs while `rpt_en` is high. All three asynchronous inputs pass through a two-flop synchronizer, and every time below is in clock cycles.

Top module: `zvt_reporter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `lo_rpt_n` and `hi_rpt_n` are 1. A high-side report that is pending when reset is applied is never issued.
- R2: When `rpt_en` is sampled 0 at a clock edge, both outputs are 1 after that edge. This cuts any pulse in progress and cancels any scheduled report.
- R3: A low-side event qualifies when `below_flag` is sampled 1 on at least QUAL_CYC+1 consecutive clock edges inside one transition. With the default of 4, five samples qualify and four do not.
- R4: A high-side event qualifies under the same rule, applied to `above_flag`.
- R5: Each report is an active-low pulse of exactly PULSE_CYC cycles (default 6). Between two pulses on the same output there is at least one cycle at 1.
- R6: If `below_flag` is first sampled 1 at edge E and then qualifies, `lo_rpt_n` goes to 0 at edge E + 2 + QUAL_CYC + LO_DLY_CYC. The 2 cycles are the synchronizer.
- R7: A qualified high-side event stays pending and is not reported within its own transition or the following one. It is reported when `li_in` next changes to the level it held when the event qualified. If that change is first sampled at edge L, `hi_rpt_n` goes to 0 at edge L + 2 + HI_DLY_CYC.
- R8: Each side produces at most one qualified event per transition. A flag held past qualification, or asserted again in the same transition, does not trigger again. After an `li_in` edge, the flag's run count starts again from zero.
- R9: A low-side event that qualifies while that side's delay-plus-pulse window is still running is dropped. A high-side event that qualifies while a high-side report is already pending is also dropped.
- R10: A pending high-side report is discarded when `rpt_en` is sampled 0, even if `rpt_en` returns to 1 before the launching `li_in` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_en | input | 1 | Reporting mode enable, synchronous to `clk` |
| li_in | input | 1 | Low-side control input, asynchronous |
| below_flag | input | 1 | Switch node below ground by threshold, asynchronous |
| above_flag | input | 1 | Switch node above supply by threshold, asynchronous |
| lo_rpt_n | output | 1 | Active-low low-side event report |
| hi_rpt_n | output | 1 | Active-low high-side event report |

## Verification
The checker assumes that `rpt_en` is already synchronous to `clk` and that `li_in` and the flags settle between edges. Each flag is assumed to stay high or low for whole cycles, so the run count after the synchronizer reflects what the switch node did. The pulse-width properties assume a pulse is cut short only by reset or by a low `rpt_en`. The bench therefore changes every input just after a falling clock edge, holds `rpt_en` steady inside each directed case, and in its random phase keeps the flag runs and `li_in` periods as whole-cycle lengths.

// File: rtl/zvt_pkg.sv
package zvt_pkg;
  localparam int SIDE_LO = 0;
  localparam int SIDE_HI = 1;
  localparam int N_SIDES = 2;

  // bits needed to hold values 0..maxv
  function automatic int cnt_bits(input int maxv);
    return (maxv < 1) ? 1 : $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/zvt_sync.sv
module zvt_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/zvt_qualifier.sv
module zvt_qualifier
  import zvt_pkg::*;
#(
  parameter int QUAL_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic flag,
  input  logic li_edge,
  output logic qual
);
  localparam int CW = cnt_bits(QUAL_CYC);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_CYC);

  logic [CW-1:0] run;
  logic          done;

  // fires on the (QUAL_CYC+1)-th consecutive high sample, once per transition
  assign qual = en && flag && !li_edge && !done && (run == QMAX);

  always_ff @(posedge clk) begin
    if (rst || !en || !flag || li_edge) run <= '0;
    else if (run != QMAX)               run <= run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || li_edge) done <= 1'b0;
    else if (qual)             done <= 1'b1;
  end
endmodule

// File: rtl/zvt_defer.sv
module zvt_defer (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic qual,
  input  logic li_lvl,
  input  logic li_edge,
  output logic launch
);
  logic pend;
  logic pend_dir;

  // one PWM period later: next edge that returns LI to the qualifying level
  assign launch = en && pend && li_edge && (li_lvl == pend_dir);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pend     <= 1'b0;
      pend_dir <= 1'b0;
    end else if (launch) begin
      pend <= 1'b0;
    end else if (qual && !pend) begin
      pend     <= 1'b1;
      pend_dir <= li_lvl;
    end
  end
endmodule

// File: rtl/zvt_pulse_timer.sv
module zvt_pulse_timer
  import zvt_pkg::*;
#(
  parameter int DLY_CYC   = 3,
  parameter int PULSE_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  output logic pulse_n
);
  localparam int TOTAL = DLY_CYC + PULSE_CYC;
  localparam int TW    = cnt_bits(TOTAL);
  localparam logic [TW-1:0] TLOAD = TW'(TOTAL);
  localparam logic [TW-1:0] TPW   = TW'(PULSE_CYC);

  logic [TW-1:0] tmr;
  logic [TW-1:0] tmr_nxt;

  always_comb begin
    if (!en)                      tmr_nxt = '0;
    else if (start && tmr == '0)  tmr_nxt = TLOAD;
    else if (tmr != '0)           tmr_nxt = tmr - 1'b1;
    else                          tmr_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= '0;
      pulse_n <= 1'b1;
    end else begin
      tmr     <= tmr_nxt;
      pulse_n <= !((tmr_nxt != '0) && (tmr_nxt <= TPW));
    end
  end
endmodule

// File: rtl/zvt_reporter.sv
module zvt_reporter
  import zvt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 4,
  parameter int PULSE_CYC   = 6,
  parameter int LO_DLY_CYC  = 3,
  parameter int HI_DLY_CYC  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic rpt_en,
  input  logic li_in,
  input  logic below_flag,
  input  logic above_flag,
  output logic lo_rpt_n,
  output logic hi_rpt_n
);
  localparam int SYNC_W = N_SIDES + 1;

  logic [SYNC_W-1:0]  sync_q;
  logic [N_SIDES-1:0] s_flag;
  logic               s_li;
  logic               li_prev;
  logic               li_edge;
  logic [N_SIDES-1:0] side_qual;
  logic [N_SIDES-1:0] tmr_start;
  logic [N_SIDES-1:0] rpt_n;
  logic               hi_launch;

  zvt_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({li_in, above_flag, below_flag}),
    .q   (sync_q)
  );

  assign s_flag = sync_q[N_SIDES-1:0];
  assign s_li   = sync_q[N_SIDES];

  always_ff @(posedge clk) begin
    if (rst) li_prev <= 1'b0;
    else     li_prev <= s_li;
  end

  assign li_edge = s_li ^ li_prev;

  zvt_defer u_defer (
    .clk     (clk),
    .rst     (rst),
    .en      (rpt_en),
    .qual    (side_qual[SIDE_HI]),
    .li_lvl  (s_li),
    .li_edge (li_edge),
    .launch  (hi_launch)
  );

  assign tmr_start[SIDE_LO] = side_qual[SIDE_LO];
  assign tmr_start[SIDE_HI] = hi_launch;

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    localparam int DLY = (g == SIDE_LO) ? LO_DLY_CYC : HI_DLY_CYC;

    zvt_qualifier #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk     (clk),
      .rst     (rst),
      .en      (rpt_en),
      .flag    (s_flag[g]),
      .li_edge (li_edge),
      .qual    (side_qual[g])
    );

    zvt_pulse_timer #(.DLY_CYC(DLY), .PULSE_CYC(PULSE_CYC)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .en      (rpt_en),
      .start   (tmr_start[g]),
      .pulse_n (rpt_n[g])
    );
  end

  assign lo_rpt_n = rpt_n[SIDE_LO];
  assign hi_rpt_n = rpt_n[SIDE_HI];
endmodule

// File: rtl/zvt_reporter_chk.sv
module zvt_reporter_chk
  import zvt_pkg::*;
#(
  parameter int QUAL_CYC  = 4,
  parameter int PULSE_CYC = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               lo_n,
  input logic               hi_n,
  input logic               li_edge,
  input logic [N_SIDES-1:0] qual,
  input logic [N_SIDES-1:0] flag
);
  localparam int PW = cnt_bits(PULSE_CYC + 1);
  localparam int RW = cnt_bits(QUAL_CYC + 1);

  logic [PW-1:0]      lo_low, hi_low;
  logic [RW-1:0]      lo_run;
  logic [N_SIDES-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_low <= '0;
      hi_low <= '0;
      lo_run <= '0;
      seen   <= '0;
    end else begin
      lo_low <= lo_n ? '0 : ((lo_low == PW'(PULSE_CYC + 1)) ? lo_low : lo_low + 1'b1);
      hi_low <= hi_n ? '0 : ((hi_low == PW'(PULSE_CYC + 1)) ? hi_low : hi_low + 1'b1);
      lo_run <= !flag[SIDE_LO] ? '0 : ((lo_run == RW'(QUAL_CYC + 1)) ? lo_run : lo_run + 1'b1);
      seen   <= (li_edge || !en) ? '0 : (seen | qual);
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (lo_n && hi_n));

  // R2
  en_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (lo_n && hi_n));

  // R5
  lo_pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
    !lo_n |-> (lo_low < PW'(PULSE_CYC)));

  // R5
  lo_pulse_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(lo_n) && $past(en) && !$past(rst)) |-> (lo_low == PW'(PULSE_CYC)));

  // R5
  hi_pulse_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hi_n) && $past(en) && !$past(rst)) |-> (hi_low == PW'(PULSE_CYC)));

  // R3
  lo_qual_len_chk: assert property (@(posedge clk) disable iff (rst)
    qual[SIDE_LO] |-> (lo_run >= RW'(QUAL_CYC)));

  // R8
  one_per_transition_chk: assert property (@(posedge clk) disable iff (rst)
    (qual & seen) == '0);
endmodule

bind zvt_reporter zvt_reporter_chk #(
  .QUAL_CYC  (QUAL_CYC),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (rpt_en),
  .lo_n    (lo_rpt_n),
  .hi_n    (hi_rpt_n),
  .li_edge (li_edge),
  .qual    (side_qual),
  .flag    (s_flag)
);

// File: tb/zvt_reporter_bench.sv
module zvt_reporter_bench;
  localparam int QUAL = 4;
  localparam int PW   = 6;
  localparam int LDLY = 3;
  localparam int HDLY = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rpt_en = 1'b0;
  logic li_in = 1'b0;
  logic below_flag = 1'b0;
  logic above_flag = 1'b0;
  logic lo_rpt_n, hi_rpt_n;

  always #2.5 clk = ~clk;

  zvt_reporter #(
    .SYNC_STAGES (2),
    .QUAL_CYC    (QUAL),
    .PULSE_CYC   (PW),
    .LO_DLY_CYC  (LDLY),
    .HI_DLY_CYC  (HDLY)
  ) u_zvt_reporter (
    .clk        (clk),
    .rst        (rst),
    .rpt_en     (rpt_en),
    .li_in      (li_in),
    .below_flag (below_flag),
    .above_flag (above_flag),
    .lo_rpt_n   (lo_rpt_n),
    .hi_rpt_n   (hi_rpt_n)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R1";
  bit    done_flag = 0;

  // behavioural reference
  bit m_li1, m_li2, m_li3;
  bit m_f1 [2];
  bit m_f2 [2];
  int m_run [2];
  bit m_done [2];
  int m_tmr [2];
  bit m_pend, m_pdir;
  bit m_lo = 1, m_hi = 1;

  always @(posedge clk) begin
    bit ed, launch;
    bit q [2];
    bit st [2];
    cyc++;
    if (rst) begin
      m_li1 = 0; m_li2 = 0; m_li3 = 0;
      for (int s = 0; s < 2; s++) begin
        m_f1[s] = 0; m_f2[s] = 0; m_run[s] = 0; m_done[s] = 0; m_tmr[s] = 0;
      end
      m_pend = 0; m_pdir = 0; m_lo = 1; m_hi = 1;
    end else begin
      ed = (m_li2 != m_li3);
      for (int s = 0; s < 2; s++)
        q[s] = rpt_en && m_f2[s] && !ed && !m_done[s] && (m_run[s] >= QUAL);
      launch = rpt_en && ed && m_pend && (m_li2 == m_pdir);
      if (!rpt_en) begin
        for (int s = 0; s < 2; s++) begin
          m_run[s] = 0; m_done[s] = 0; m_tmr[s] = 0;
        end
        m_pend = 0;
      end else begin
        st[0] = q[0];
        st[1] = launch;
        for (int s = 0; s < 2; s++) begin
          m_run[s]  = (!m_f2[s] || ed) ? 0 : m_run[s] + 1;
          m_done[s] = ed ? 0 : (m_done[s] || q[s]);
          if (st[s] && m_tmr[s] == 0) m_tmr[s] = ((s == 0) ? LDLY : HDLY) + PW;
          else if (m_tmr[s] > 0)      m_tmr[s]--;
        end
        if (launch) m_pend = 0;
        else if (q[1] && !m_pend) begin
          m_pend = 1;
          m_pdir = m_li2;
        end
      end
      m_lo = !(m_tmr[0] != 0 && m_tmr[0] <= PW);
      m_hi = !(m_tmr[1] != 0 && m_tmr[1] <= PW);
      m_li3 = m_li2; m_li2 = m_li1; m_li1 = li_in;
      m_f2[0] = m_f1[0]; m_f2[1] = m_f1[1];
      m_f1[0] = below_flag; m_f1[1] = above_flag;
    end
  end

  // per-cycle comparison and fall counting
  bit prev_lo = 1, prev_hi = 1;
  int lo_falls = 0, hi_falls = 0;
  int lo_fall_cyc = 0, hi_fall_cyc = 0;

  always @(negedge clk) begin
    if (cyc >= 1 && !done_flag) begin
      n_cmp++;
      if (lo_rpt_n !== m_lo || hi_rpt_n !== m_hi) begin
        n_bad++;
        $display("FAIL %s cycle %0d: lo/hi actual %b%b expected %b%b",
                 cur_req, cyc, lo_rpt_n, hi_rpt_n, m_lo, m_hi);
      end
      if (prev_lo && !lo_rpt_n) begin lo_falls++; lo_fall_cyc = cyc; end
      if (prev_hi && !hi_rpt_n) begin hi_falls++; hi_fall_cyc = cyc; end
      prev_lo = lo_rpt_n;
      prev_hi = hi_rpt_n;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected finish before 150000", cyc);
      finish_run();
    end
  end

  initial begin
    int t0, lf, hf;
    // R1: reset state
    cur_req = "R1";
    tick(4);
    check("R1 lo idle in reset", lo_rpt_n, 1);
    check("R1 hi idle in reset", hi_rpt_n, 1);
    rst = 0;
    tick(1);
    check("R1 lo idle after reset", lo_rpt_n, 1);
    rpt_en = 1;
    tick(10);

    // R3 R6 R5: five samples qualify, latency 3+QUAL+LDLY from drive
    cur_req = "R6";
    lf = lo_falls; t0 = cyc;
    below_flag = 1; tick(5); below_flag = 0;
    tick(30);
    check("R3 five-sample run reports", lo_falls - lf, 1);
    check("R6 low-side latency", lo_fall_cyc - t0, 3 + QUAL + LDLY);

    // R3: four samples are ignored
    cur_req = "R3";
    lf = lo_falls;
    below_flag = 1; tick(4); below_flag = 0;
    tick(40);
    check("R3 four-sample run ignored", lo_falls - lf, 0);
    check("R3 lo idle after short run", lo_rpt_n, 1);

    // R8: held flag and second run in same transition give one report
    cur_req = "R8";
    lf = lo_falls;
    li_in = 1; tick(6);
    below_flag = 1; tick(20); below_flag = 0; tick(2);
    below_flag = 1; tick(8); below_flag = 0;
    tick(30);
    check("R8 one report per transition", lo_falls - lf, 1);

    // R4 R7: high-side event deferred one PWM period
    cur_req = "R7";
    hf = hi_falls;
    tick(5);
    above_flag = 1; tick(6); above_flag = 0; tick(10);
    check("R4 no high report within own transition", hi_falls - hf, 0);
    li_in = 0; tick(15);
    check("R7 no high report on opposite edge", hi_falls - hf, 0);
    t0 = cyc;
    li_in = 1; tick(30);
    check("R4 high event reported", hi_falls - hf, 1);
    check("R7 high-side latency from LI edge", hi_fall_cyc - t0, 3 + HDLY);

    // R9: low event during running window dropped
    cur_req = "R9";
    lf = lo_falls;
    li_in = 0; tick(6);
    below_flag = 1; tick(5);
    li_in = 1; tick(10);
    below_flag = 0; tick(30);
    check("R9 low event while busy dropped", lo_falls - lf, 1);

    // R9: second high event while pending dropped
    hf = hi_falls;
    above_flag = 1; tick(6); above_flag = 0; tick(3);
    li_in = 0; tick(4);
    above_flag = 1; tick(6); above_flag = 0; tick(3);
    li_in = 1; tick(30);
    check("R9 first pending high reported", hi_falls - hf, 1);
    li_in = 0; tick(30);
    check("R9 second high event dropped", hi_falls - hf, 1);

    // R10: enable drop discards pending high report
    cur_req = "R10";
    hf = hi_falls;
    above_flag = 1; tick(6); above_flag = 0; tick(3);
    rpt_en = 0; tick(3); rpt_en = 1; tick(3);
    li_in = 1; tick(10); li_in = 0; tick(30);
    check("R10 pending discarded by enable", hi_falls - hf, 0);

    // R2: enable drop cuts a running pulse
    cur_req = "R2";
    li_in = 1; tick(6);
    below_flag = 1; tick(5); below_flag = 0;
    for (int i = 0; i < 40 && lo_rpt_n; i++) tick(1);
    check("R2 pulse started", lo_rpt_n, 0);
    rpt_en = 0; tick(1);
    check("R2 lo idle after enable drop", lo_rpt_n, 1);
    check("R2 hi idle after enable drop", hi_rpt_n, 1);
    tick(3); rpt_en = 1; tick(20);

    // R1: reset discards pending high report
    cur_req = "R1";
    hf = hi_falls;
    above_flag = 1; tick(6); above_flag = 0; tick(3);
    rst = 1; tick(2);
    check("R1 outputs idle during reset", lo_rpt_n & hi_rpt_n, 1);
    rst = 0; tick(3);
    li_in = 0; tick(10); li_in = 1; tick(10); li_in = 0; tick(30);
    check("R1 pending discarded by reset", hi_falls - hf, 0);

    // mixed random traffic, compared cycle by cycle
    cur_req = "mixed";
    for (int k = 0; k < 400; k++) begin
      int len;
      len = 3 + int'($urandom_range(0, 14));
      li_in = ~li_in;
      below_flag = $urandom_range(0, 1);
      above_flag = $urandom_range(0, 1);
      if ($urandom_range(0, 40) == 0) rpt_en = 0;
      else rpt_en = 1;
      tick(len);
      below_flag = 0; above_flag = 0;
      tick(int'($urandom_range(0, 4)));
    end
    tick(40);
    finish_run();
  end
endmodule